// File: doc/BRIEF.md
# Timing Reference Selection Mode Controller

This block decides how a timing module is steered. There are three states. In Free Run the module uses no reference. In Holdover it keeps the last learned frequency. In Locked it follows one of four references, and the block also names which reference is active. Each reference comes with a qualified flag. Software supplies a per-reference mask bit, a priority value for each reference, a revertive bit and an autonomous/manual bit. In manual operation the mode and the reference come from command inputs. In autonomous operation the block picks the best eligible reference by itself.

The state machine has three states: `ST_FREE`, `ST_HOLD` and `ST_LOCK`. It uses these transitions:
- free→lock and hold→lock when an eligible reference (or the commanded one) appears.
- lock→lock with a new index on failover or reversion.
- lock→hold when the active reference fails and nothing else is usable.
- any→free on a manual Free Run command, or on a fallback before any lock has occurred.
- any→hold on a manual Holdover command after a lock.

An active-low interrupt latches on any change of mode or active reference and is released by a clear strobe. A separate alarm flags a failed active reference.

Top module: `refsel_ctrl`

## Requirements
- R1: After reset `mode` is 0 (Free Run), `act_ref` is 0, `int_n` is 1 and `alarm` is 0.
- R2: `mode` encodes 0 = Free Run, 1 = Holdover, 2 = Locked. In manual operation, a `man_mode` command of 0 or 3 gives Free Run one cycle later.
- R3: In manual operation, `man_mode` = 2 locks onto `man_ref` one cycle later if that reference is eligible, whatever its priority. If it is not eligible, the block falls back (see R9). `man_mode` = 1 also falls back.
- R4: A reference is eligible only when its `ref_qual` bit is 1 and its `ref_mask` bit is 0.
- R5: In autonomous operation the block locks onto the eligible reference with the smallest priority value. Reference i's priority sits in `ref_prio[3i+2:3i]`. On equal values the lower index wins.
- R6: In autonomous operation, when the active reference becomes ineligible, the block moves the next cycle to the best other eligible reference. If there is none, it goes to Holdover.
- R7: With `revertive` = 1 in autonomous operation, the block moves to a better eligible reference as soon as one exists.
- R8: With `revertive` = 0 in autonomous operation, the block keeps the active reference as long as it stays eligible, even when a better one returns.
- R9: A fallback goes to Holdover only if the block has been Locked at least once since reset; otherwise it goes to Free Run.
- R10: `int_n` goes low at the edge where `mode` or `act_ref` changes. It stays low until an `int_clr` pulse in a cycle with no new change. When a change and a clear happen in the same cycle, the change wins.
- R11: `alarm` rises at the edge where Locked is left or redirected because the active reference became ineligible. It falls at the first later edge that finds the block Locked on an eligible reference.
- R12: While not Locked, `act_ref` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_qual | input | 4 | Per-reference qualified flag |
| ref_mask | input | 4 | Per-reference mask, 1 = excluded |
| ref_prio | input | 12 | Priority per reference, 3 bits each, smaller is preferred |
| revertive | input | 1 | 1 = return to best reference, 0 = keep current |
| autonomous | input | 1 | 1 = automatic selection, 0 = manual commands |
| man_mode | input | 2 | Manual mode command (0/3 free, 1 hold, 2 lock) |
| man_ref | input | 2 | Manual reference command |
| int_clr | input | 1 | Interrupt clear strobe |
| act_ref | output | 2 | Active reference index |
| mode | output | 2 | Current operating mode |
| int_n | output | 1 | Active-low status-change interrupt |
| alarm | output | 1 | Active reference failure flag |

## Verification
The bench gives two references the same priority. A selector with the wrong tie rule would lock onto the higher index. It requalifies an earlier reference in both revertive and non-revertive settings. Swapping the behaviour of the two settings would show up as a move that should not happen, or a missing one. It asks for Holdover before any lock, where a design without lock history would report Holdover instead of Free Run. It also drops every reference after a lock to check that the index is held and the alarm comes and goes in the correct cycles. Interrupt checks clear the latch with no pending change and confirm it stays released, so a level-style interrupt or a lost clear would be caught.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
    localparam logic [1:0] MODE_FREE = 2'd0;
    localparam logic [1:0] MODE_HOLD = 2'd1;
    localparam logic [1:0] MODE_LOCK = 2'd2;

    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_HOLD = 2'd1,
        ST_LOCK = 2'd2
    } sel_state_e;
endpackage

// File: rtl/refsel_pick.sv
module refsel_pick #(
    parameter int NREF   = 4,
    parameter int PRIO_W = 3,
    parameter int REF_W  = $clog2(NREF)
) (
    input  logic [NREF-1:0]        elig,
    input  logic [NREF*PRIO_W-1:0] prio_flat,
    output logic                   best_valid,
    output logic [REF_W-1:0]       best_idx
);
    logic [PRIO_W-1:0] best_p;

    // Linear scan: strict less-than keeps the lower index on ties.
    always_comb begin
        best_valid = 1'b0;
        best_idx   = '0;
        best_p     = '1;
        for (int i = 0; i < NREF; i++) begin
            if (elig[i] && (!best_valid || prio_flat[i*PRIO_W +: PRIO_W] < best_p)) begin
                best_valid = 1'b1;
                best_idx   = REF_W'(i);
                best_p     = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/refsel_irq.sv
module refsel_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic status_chg,
    input  logic int_clr,
    input  logic fail_evt,
    input  logic locked_ok,
    output logic int_n,
    output logic alarm
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_n <= 1'b1;
            alarm <= 1'b0;
        end else begin
            if (status_chg)   int_n <= 1'b0;
            else if (int_clr) int_n <= 1'b1;

            if (fail_evt)       alarm <= 1'b1;
            else if (locked_ok) alarm <= 1'b0;
        end
    end

    assert_int_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        status_chg |=> !int_n);
    assert_int_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_n && !int_clr) |=> !int_n);
    assert_alarm_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fail_evt |=> alarm);
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
    import refsel_pkg::*;
#(
    parameter int NREF   = 4,
    parameter int PRIO_W = 3,
    localparam int REF_W = $clog2(NREF)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREF-1:0]        ref_qual,
    input  logic [NREF-1:0]        ref_mask,
    input  logic [NREF*PRIO_W-1:0] ref_prio,
    input  logic                   revertive,
    input  logic                   autonomous,
    input  logic [1:0]             man_mode,
    input  logic [REF_W-1:0]       man_ref,
    input  logic                   int_clr,
    output logic [REF_W-1:0]       act_ref,
    output logic [1:0]             mode,
    output logic                   int_n,
    output logic                   alarm
);
    sel_state_e       st, st_nx;
    logic [REF_W-1:0] act_q, ref_nx;
    logic             ever_locked;
    logic [NREF-1:0]  elig;
    logic             best_valid;
    logic [REF_W-1:0] best_idx;
    sel_state_e       fallback;
    logic             status_chg, fail_evt, locked_ok;

    assign elig = ref_qual & ~ref_mask;

    refsel_pick #(.NREF(NREF), .PRIO_W(PRIO_W), .REF_W(REF_W)) u_pick (
        .elig       (elig),
        .prio_flat  (ref_prio),
        .best_valid (best_valid),
        .best_idx   (best_idx)
    );

    assign fallback = ever_locked ? ST_HOLD : ST_FREE;

    // Next-state logic
    always_comb begin
        st_nx  = st;
        ref_nx = act_q;
        if (!autonomous) begin
            unique case (man_mode)
                MODE_LOCK: begin
                    if (elig[man_ref]) begin
                        st_nx  = ST_LOCK;
                        ref_nx = man_ref;
                    end else begin
                        st_nx = fallback;
                    end
                end
                MODE_HOLD: st_nx = fallback;
                default:   st_nx = ST_FREE;
            endcase
        end else begin
            unique case (st)
                ST_LOCK: begin
                    if (!elig[act_q]) begin
                        if (best_valid) ref_nx = best_idx;
                        else            st_nx  = ST_HOLD;
                    end else if (revertive && best_valid) begin
                        ref_nx = best_idx;
                    end
                end
                ST_HOLD, ST_FREE: begin
                    if (best_valid) begin
                        st_nx  = ST_LOCK;
                        ref_nx = best_idx;
                    end
                end
                default: st_nx = ST_FREE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st          <= ST_FREE;
            act_q       <= '0;
            ever_locked <= 1'b0;
        end else begin
            st    <= st_nx;
            act_q <= ref_nx;
            if (st_nx == ST_LOCK) ever_locked <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        act_ref = act_q;
        unique case (st)
            ST_LOCK: mode = MODE_LOCK;
            ST_HOLD: mode = MODE_HOLD;
            default: mode = MODE_FREE;
        endcase
    end

    assign status_chg = (st_nx != st) || (ref_nx != act_q);
    assign fail_evt   = (st == ST_LOCK) && !elig[act_q];
    assign locked_ok  = (st == ST_LOCK) && elig[act_q];

    refsel_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .status_chg (status_chg),
        .int_clr    (int_clr),
        .fail_evt   (fail_evt),
        .locked_ok  (locked_ok),
        .int_n      (int_n),
        .alarm      (alarm)
    );

    assert_hold_needs_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |-> ever_locked);
    assert_free_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!autonomous && (man_mode == MODE_FREE)) |=> (mode == MODE_FREE));
    assert_failover_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (autonomous && fail_evt) |=> ((mode != MODE_LOCK) || (act_ref != $past(act_ref))));
    assert_nonrev_stay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (autonomous && !revertive && (mode == MODE_LOCK) && elig[act_ref])
        |=> ((mode == MODE_LOCK) && $stable(act_ref)));
    assert_ref_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode != MODE_LOCK) && (st_nx != ST_LOCK)) |=> $stable(act_ref));
endmodule

// File: tb/refsel_ctrl_bench.sv
`timescale 1ns/1ps
module refsel_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  ref_qual, ref_mask;
    logic [11:0] ref_prio;
    logic        revertive, autonomous, int_clr;
    logic [1:0]  man_mode, man_ref;
    logic [1:0]  act_ref, mode;
    logic        int_n, alarm;
    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    refsel_ctrl u_refsel_ctrl (
        .clk(clk), .rst_n(rst_n), .ref_qual(ref_qual), .ref_mask(ref_mask),
        .ref_prio(ref_prio), .revertive(revertive), .autonomous(autonomous),
        .man_mode(man_mode), .man_ref(man_ref), .int_clr(int_clr),
        .act_ref(act_ref), .mode(mode), .int_n(int_n), .alarm(alarm)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ref_qual = 4'h0; ref_mask = 4'h0; ref_prio = 12'h0;
        revertive = 1'b1; autonomous = 1'b0; man_mode = 2'd0; man_ref = 2'd0;
        int_clr = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 mode", mode, 0);
        chk("R1 act_ref", act_ref, 0);
        chk("R1 int_n", int_n, 1);
        chk("R1 alarm", alarm, 0);
    endtask

    task automatic t_manual();
        do_reset();
        ref_qual = 4'hF;
        ref_prio = {3'd0, 3'd7, 3'd0, 3'd0};
        man_mode = 2'd1; tick();
        chk("R9 hold before lock gives free", mode, 0);
        man_mode = 2'd2; man_ref = 2'd2; tick();
        chk("R3 manual lock mode", mode, 2);
        chk("R3 manual ref ignores priority", act_ref, 2);
        chk("R10 int low on change", int_n, 0);
        int_clr = 1'b1; tick(); int_clr = 1'b0;
        chk("R10 int released by clear", int_n, 1);
        tick();
        chk("R10 int stays high without change", int_n, 1);
        ref_mask = 4'b0100; tick();
        chk("R4 masked ref gives holdover", mode, 1);
        chk("R11 alarm on failure", alarm, 1);
        chk("R10 int low on fallback", int_n, 0);
        man_mode = 2'd3; tick();
        chk("R2 code 3 gives free", mode, 0);
        chk("R12 ref held when not locked", act_ref, 2);
    endtask

    task automatic t_revertive();
        do_reset();
        autonomous = 1'b1; revertive = 1'b1; ref_qual = 4'hF;
        ref_prio = {3'd5, 3'd1, 3'd1, 3'd3};
        tick();
        chk("R5 locked", mode, 2);
        chk("R5 tie to lower index", act_ref, 1);
        ref_qual = 4'b1101; tick();
        chk("R6 failover ref", act_ref, 2);
        chk("R6 still locked", mode, 2);
        chk("R11 alarm raised", alarm, 1);
        tick();
        chk("R11 alarm cleared after relock", alarm, 0);
        ref_qual = 4'hF; tick();
        chk("R7 revert to best", act_ref, 1);
    endtask

    task automatic t_nonrevertive();
        do_reset();
        autonomous = 1'b1; revertive = 1'b0; ref_qual = 4'hF;
        ref_prio = {3'd5, 3'd1, 3'd1, 3'd3};
        tick();
        chk("R5 initial pick", act_ref, 1);
        ref_qual = 4'b1101; tick();
        chk("R6 failover nonrev", act_ref, 2);
        ref_qual = 4'hF; tick(); tick();
        chk("R8 no return", act_ref, 2);
        ref_qual = 4'b1011; tick();
        chk("R8 returns when current fails", act_ref, 1);
        ref_qual = 4'h0; tick();
        chk("R6 none left gives holdover", mode, 1);
        chk("R12 ref held in holdover", act_ref, 1);
        chk("R11 alarm in holdover", alarm, 1);
        tick();
        chk("R11 alarm persists unlocked", alarm, 1);
        ref_qual = 4'b1000; tick();
        chk("R6 relock on lone ref", act_ref, 3);
        chk("R11 alarm until next edge", alarm, 1);
        tick();
        chk("R11 alarm cleared", alarm, 0);
    endtask

    task automatic t_norefs();
        do_reset();
        autonomous = 1'b1; ref_qual = 4'hF; ref_mask = 4'hF;
        tick(); tick();
        chk("R9 free run with no lock", mode, 0);
        chk("R4 all masked no interrupt", int_n, 1);
    endtask

    initial begin
        t_reset();
        t_manual();
        t_revertive();
        t_nonrevertive();
        t_norefs();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule